// File: doc/BRIEF.md
# Single-Cycle Integer Core with Host Mailbox

This block is a 32-bit processor that completes one instruction per clock cycle. Each instruction is a fixed 32 bits wide. It executes a deliberately tiny instruction subset: two additions, a multiply, word load and store, three jumps, a not-equal branch, a no-operation, and two coprocessor moves. The coprocessor moves are the only path to a test host. One of them pushes a register value out through a valid/ready output channel. The other pulls a word in through a valid/ready input channel.

Instruction memory is read combinationally at the address the block presents. Data memory is read combinationally and written at the clock edge while the write strobe is high. Taken control transfers have no delay slot: the instruction that follows a taken branch or jump is never executed.

The control is a two-state machine.
- ST_RUN executes the fetched word.
- ST_FAULT is entered on the transition "illegal word seen" and is left only through the transition "reset". Reset always lands in ST_RUN.

In ST_FAULT the core is frozen and raises a sticky error output.

Top module: `tiny_core`

## Requirements
- R1: A synchronous, active-high reset sets the fetch address to 0x00000200, clears all 32 registers to zero, clears the error flag and selects ST_RUN.
- R2: addu (opcode 0x00, funct 0x21, shamt 0) writes rs+rt to rd. addiu (opcode 0x09) writes rs plus the sign-extended 16-bit immediate to rt. mul (opcode 0x1C, funct 0x02) writes the low 32 bits of rs*rt to rd. None of them traps on overflow.
- R3: Register 0 always reads as zero, and any write aimed at it is discarded.
- R4: lw (opcode 0x23) and sw (opcode 0x2B) use the address rs plus the sign-extended immediate. lw writes the data-memory word to rt. sw drives rt onto the write-data port with the write strobe high for that one cycle.
- R5: bne (opcode 0x05), when rs differs from rt, fetches next from PC+4 plus the sign-extended immediate shifted left by 2. Otherwise it falls through to PC+4. A taken branch never executes the word that follows it.
- R6: j (opcode 0x02) and jal (opcode 0x03) go to the top 4 bits of PC+4 joined with the 26-bit target shifted left by 2. jal also writes PC+4 into register 31. jr (opcode 0x00, funct 0x08, other fields zero) goes to the value of rs.
- R7: The move-to-host form (opcode 0x10, rs field 0x04, rd field 21, low 11 bits zero) drives rt on tx_data with tx_valid high. The PC holds, with tx_data stable, until tx_ready is high at a clock edge.
- R8: The move-from-host form (opcode 0x10, rs field 0x00, rd field 20, low 11 bits zero) raises rx_ready. It writes rx_data into rt and advances only at an edge where rx_valid is high. Until then it holds the PC.
- R9: Any other word moves the core to ST_FAULT. In ST_FAULT, err stays high until reset, the fetch address is frozen, and there are no register writes, memory writes or host strobes. The all-zero word is a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch address (current PC) |
| imem_data | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data-memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, write at clock edge |
| dmem_rdata | input | 32 | Load data at dmem_addr |
| tx_data | output | 32 | Word sent to the host |
| tx_valid | output | 1 | tx_data is offered |
| tx_ready | input | 1 | Host accepts tx_data |
| rx_data | input | 32 | Word from the host |
| rx_valid | input | 1 | rx_data is offered |
| rx_ready | output | 1 | Core wants a host word |
| err | output | 1 | Sticky illegal-instruction flag |

## Verification
The checker watches every cycle for four behaviours:
- the reset fetch address;
- PC and tx_data holding while either host handshake is incomplete;
- err staying high once it is set;
- the frozen, silent behaviour of ST_FAULT.

Arithmetic results, load/store addressing, branch and jump targets, the absent delay slot and the value stored by jal can only be shown by the bench's programs. The bench sees them through the words the core sends to the host and through the data memory the bench models.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam logic [5:0] OP_SPECIAL  = 6'h00;
    localparam logic [5:0] OP_J        = 6'h02;
    localparam logic [5:0] OP_JAL      = 6'h03;
    localparam logic [5:0] OP_BNE      = 6'h05;
    localparam logic [5:0] OP_ADDIU    = 6'h09;
    localparam logic [5:0] OP_COP      = 6'h10;
    localparam logic [5:0] OP_SPECIAL2 = 6'h1C;
    localparam logic [5:0] OP_LW       = 6'h23;
    localparam logic [5:0] OP_SW       = 6'h2B;

    localparam logic [5:0] FN_JR   = 6'h08;
    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_MUL  = 6'h02;

    localparam logic [4:0] CP_FROM      = 5'h00;
    localparam logic [4:0] CP_TO        = 5'h04;
    localparam logic [4:0] CPR_HOST_IN  = 5'd20;
    localparam logic [4:0] CPR_HOST_OUT = 5'd21;
    localparam logic [4:0] LINK_REG     = 5'd31;

    typedef enum logic [3:0] {
        K_NOP, K_ADDU, K_ADDIU, K_MUL, K_LW, K_SW,
        K_J, K_JAL, K_JR, K_BNE, K_MFC, K_MTC, K_BAD
    } kind_e;

    typedef struct packed {
        kind_e       kind;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  rd;
        logic [15:0] imm;
        logic [25:0] tgt;
    } dec_t;

    typedef enum logic {ST_RUN, ST_FAULT} state_e;

endpackage

// File: rtl/core_decode.sv
module core_decode
    import core_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);

    always_comb begin
        dec.rs   = instr[25:21];
        dec.rt   = instr[20:16];
        dec.rd   = instr[15:11];
        dec.imm  = instr[15:0];
        dec.tgt  = instr[25:0];
        dec.kind = K_BAD;
        unique case (instr[31:26])
            OP_SPECIAL: begin
                if (instr == 32'd0)
                    dec.kind = K_NOP;
                else if (instr[10:6] == 5'd0 && instr[5:0] == FN_ADDU)
                    dec.kind = K_ADDU;
                else if (instr[20:6] == 15'd0 && instr[5:0] == FN_JR)
                    dec.kind = K_JR;
            end
            OP_SPECIAL2: begin
                if (instr[10:0] == {5'd0, FN_MUL})
                    dec.kind = K_MUL;
            end
            OP_ADDIU: dec.kind = K_ADDIU;
            OP_LW:    dec.kind = K_LW;
            OP_SW:    dec.kind = K_SW;
            OP_J:     dec.kind = K_J;
            OP_JAL:   dec.kind = K_JAL;
            OP_BNE:   dec.kind = K_BNE;
            OP_COP: begin
                if (instr[10:0] == 11'd0) begin
                    if (instr[25:21] == CP_FROM && instr[15:11] == CPR_HOST_IN)
                        dec.kind = K_MFC;
                    else if (instr[25:21] == CP_TO && instr[15:11] == CPR_HOST_OUT)
                        dec.kind = K_MTC;
                end
            end
            default: dec.kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/core_regs.sv
module core_regs #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] bank [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) bank[i] <= '0;
        end else if (we && wa != '0) begin
            bank[wa] <= wd;
        end
    end

    assign rd_a = (ra == '0) ? '0 : bank[ra];
    assign rd_b = (rb == '0) ? '0 : bank[rb];

endmodule

// File: rtl/tiny_core.sv
module tiny_core
    import core_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0200
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata,
    output logic [31:0] tx_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    input  logic [31:0] rx_data,
    input  logic        rx_valid,
    output logic        rx_ready,
    output logic        err
);

    state_e      state, state_next;
    logic [31:0] pc, pc_next, pc4, tgt_pc, simm;
    logic [31:0] rs_v, rt_v, wdata;
    logic [4:0]  waddr;
    logic        wen, advance;
    dec_t        dec;

    core_decode u_dec (
        .instr (imem_data),
        .dec   (dec)
    );

    core_regs #(.NREG(32), .W(32)) u_regs (
        .clk  (clk),
        .rst  (rst),
        .ra   (dec.rs),
        .rb   (dec.rt),
        .rd_a (rs_v),
        .rd_b (rt_v),
        .we   (wen),
        .wa   (waddr),
        .wd   (wdata)
    );

    assign pc4        = pc + 32'd4;
    assign simm       = {{16{dec.imm[15]}}, dec.imm};
    assign imem_addr  = pc;
    assign dmem_addr  = rs_v + simm;
    assign dmem_wdata = rt_v;
    assign tx_data    = rt_v;
    assign err        = (state == ST_FAULT);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            pc    <= RESET_PC;
        end else begin
            state <= state_next;
            pc    <= pc_next;
        end
    end

    // next state and outputs
    always_comb begin
        state_next = state;
        advance    = 1'b0;
        tgt_pc     = pc4;
        wen        = 1'b0;
        waddr      = dec.rd;
        wdata      = '0;
        dmem_we    = 1'b0;
        tx_valid   = 1'b0;
        rx_ready   = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (dec.kind == K_BAD) begin
                    state_next = ST_FAULT;
                end else begin
                    advance = 1'b1;
                    unique case (dec.kind)
                        K_ADDU: begin
                            wen = 1'b1; wdata = rs_v + rt_v;
                        end
                        K_ADDIU: begin
                            wen = 1'b1; waddr = dec.rt; wdata = rs_v + simm;
                        end
                        K_MUL: begin
                            wen = 1'b1; wdata = rs_v * rt_v;
                        end
                        K_LW: begin
                            wen = 1'b1; waddr = dec.rt; wdata = dmem_rdata;
                        end
                        K_SW: dmem_we = 1'b1;
                        K_J:  tgt_pc = {pc4[31:28], dec.tgt, 2'b00};
                        K_JAL: begin
                            tgt_pc = {pc4[31:28], dec.tgt, 2'b00};
                            wen = 1'b1; waddr = LINK_REG; wdata = pc4;
                        end
                        K_JR: tgt_pc = rs_v;
                        K_BNE: begin
                            if (rs_v != rt_v) tgt_pc = pc4 + {simm[29:0], 2'b00};
                        end
                        K_MFC: begin
                            rx_ready = 1'b1;
                            advance  = rx_valid;
                            wen      = rx_valid;
                            waddr    = dec.rt;
                            wdata    = rx_data;
                        end
                        K_MTC: begin
                            tx_valid = 1'b1;
                            advance  = tx_ready;
                        end
                        default: ;
                    endcase
                end
            end
            ST_FAULT: state_next = ST_FAULT;
        endcase
        pc_next = advance ? tgt_pc : pc;
    end

endmodule

// File: rtl/core_chk.sv
module core_chk #(
    parameter logic [31:0] RESET_PC = 32'h0000_0200
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic        dmem_we,
    input logic [31:0] tx_data,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic        err
);

    // R1
    reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (imem_addr == RESET_PC && !err));

    // R7
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> ($stable(imem_addr) && tx_valid && $stable(tx_data)));

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && !rx_valid) |=> $stable(imem_addr));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R9
    err_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> $stable(imem_addr));

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (!dmem_we && !tx_valid && !rx_ready));

endmodule

bind tiny_core core_chk #(.RESET_PC(RESET_PC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .dmem_we   (dmem_we),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .err       (err)
);

// File: tb/tb_tiny_core.sv
module tb_tiny_core;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic [31:0] tx_data, rx_data;
    logic        tx_valid, rx_ready, err;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tiny_core dut (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .err(err)
    );

    logic [31:0] imem [512];
    logic [31:0] dmem [256];
    logic [31:0] tx_log [64];
    logic [31:0] rx_list [8];
    logic [31:0] mdl [8];
    int tx_cnt = 0, rx_idx = 0, pa = 128;
    int n_chk = 0, n_bad = 0;
    logic rx_take = 1'b0;

    assign imem_data  = imem[imem_addr[10:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];
    assign rx_data    = rx_list[rx_idx[2:0]];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

    // host model: change handshake inputs away from the edge, log after settling
    always @(negedge clk) begin
        if (rx_take) rx_idx = rx_idx + 1;
        tx_ready = ($urandom % 4) != 0;
        rx_valid = ($urandom % 4) != 0;
        #1;
        rx_take = !rst && rx_valid && rx_ready;
        if (!rst && tx_valid && tx_ready) begin
            if (tx_cnt < 64) tx_log[tx_cnt] = tx_data;
            tx_cnt = tx_cnt + 1;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] e_r(logic [5:0] op, logic [4:0] s, logic [4:0] t,
                                        logic [4:0] d, logic [5:0] fn);
        return {op, s, t, d, 5'd0, fn};
    endfunction
    function automatic logic [31:0] e_i(logic [5:0] op, logic [4:0] s, logic [4:0] t,
                                        logic [15:0] im);
        return {op, s, t, im};
    endfunction
    function automatic logic [31:0] e_j(logic [5:0] op, logic [25:0] t);
        return {op, t};
    endfunction
    function automatic logic [31:0] e_to(logic [4:0] t);
        return {6'h10, 5'h04, t, 5'd21, 11'd0};
    endfunction
    function automatic logic [31:0] e_from(logic [4:0] t);
        return {6'h10, 5'h00, t, 5'd20, 11'd0};
    endfunction
    function automatic logic [31:0] sx(logic [15:0] im);
        return {{16{im[15]}}, im};
    endfunction

    task automatic clear_prog();
        for (int i = 0; i < 512; i++) imem[i] = 32'hFFFF_FFFF;
        for (int i = 0; i < 256; i++) dmem[i] = 32'd0;
        pa = 128;
    endtask

    task automatic emit(logic [31:0] w);
        imem[pa] = w;
        pa = pa + 1;
    endtask

    task automatic emit_halt();
        emit(e_j(6'h02, 26'(pa)));
    endtask

    task automatic run(int n_tx, bit chk_reset);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        tx_cnt = 0;
        rx_idx = 0;
        rx_take = 1'b0;
        if (chk_reset) begin
            chk("R1 reset fetch address", imem_addr, 32'h200);
            chk("R1 reset err", {31'd0, err}, 32'd0);
        end
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (tx_cnt >= n_tx) break;
        end
        repeat (6) @(negedge clk);
        #2;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1 actual=timeout expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rx_list[0] = 32'h1111_1111;
        rx_list[1] = 32'h2222_2222;
        for (int i = 2; i < 8; i++) rx_list[i] = 32'hDEAD_0000 + i;

        // arithmetic and register zero
        clear_prog();
        emit(e_i(6'h09, 5'd0, 5'd1, 16'd5));
        emit(e_i(6'h09, 5'd0, 5'd2, 16'hFFFD));
        emit(e_r(6'h00, 5'd1, 5'd2, 5'd3, 6'h21));
        emit(e_r(6'h1C, 5'd1, 5'd2, 5'd4, 6'h02));
        emit(e_i(6'h09, 5'd0, 5'd0, 16'd7));
        emit(32'd0);
        emit(e_to(5'd3));
        emit(e_to(5'd4));
        emit(e_to(5'd0));
        emit_halt();
        run(3, 1'b1);
        chk("R2 addu 5+(-3)", tx_log[0], 32'd2);
        chk("R2 mul low word", tx_log[1], 32'hFFFF_FFF1);
        chk("R3 r0 after write", tx_log[2], 32'd0);
        chk("R9 no fault on legal code", {31'd0, err}, 32'd0);

        // load and store
        clear_prog();
        emit(e_i(6'h09, 5'd0, 5'd1, 16'h0100));
        emit(e_i(6'h09, 5'd0, 5'd2, 16'h1234));
        emit(e_i(6'h2B, 5'd1, 5'd2, 16'd8));
        emit(e_i(6'h2B, 5'd1, 5'd1, 16'hFFF8));
        emit(e_i(6'h23, 5'd1, 5'd3, 16'd8));
        emit(e_i(6'h23, 5'd1, 5'd4, 16'hFFF8));
        emit(e_to(5'd3));
        emit(e_to(5'd4));
        emit_halt();
        run(2, 1'b0);
        chk("R4 store +8", dmem[66], 32'h1234);
        chk("R4 store -8", dmem[62], 32'h0100);
        chk("R4 load +8", tx_log[0], 32'h1234);
        chk("R4 load -8", tx_log[1], 32'h0100);

        // control flow
        clear_prog();
        emit(e_i(6'h09, 5'd0, 5'd1, 16'd1));        // 200
        emit(e_i(6'h05, 5'd1, 5'd0, 16'd1));        // 204 taken
        emit(e_i(6'h09, 5'd0, 5'd2, 16'd99));       // 208 skipped
        emit(e_to(5'd2));                           // 20C
        emit(e_i(6'h05, 5'd0, 5'd0, 16'd1));        // 210 not taken
        emit(e_i(6'h09, 5'd0, 5'd3, 16'd7));        // 214
        emit(e_to(5'd3));                           // 218
        emit(e_j(6'h03, 26'h8A));                   // 21C jal 228
        emit(e_i(6'h09, 5'd0, 5'd3, 16'd55));       // 220 skipped
        emit(e_i(6'h09, 5'd0, 5'd3, 16'd66));       // 224 skipped
        emit(e_to(5'd31));                          // 228
        emit(e_i(6'h09, 5'd0, 5'd4, 16'h023C));     // 22C
        emit(e_r(6'h00, 5'd4, 5'd0, 5'd0, 6'h08));  // 230 jr
        emit(e_to(5'd3));                           // 234 skipped
        emit(e_to(5'd3));                           // 238 skipped
        emit(e_to(5'd4));                           // 23C
        emit(e_j(6'h02, 26'h93));                   // 240 j 24C
        emit(e_to(5'd3));                           // 244 skipped
        emit(e_to(5'd3));                           // 248 skipped
        emit(e_i(6'h09, 5'd0, 5'd5, 16'd3));        // 24C
        emit(e_i(6'h09, 5'd5, 5'd5, 16'hFFFF));     // 250
        emit(e_i(6'h09, 5'd6, 5'd6, 16'd2));        // 254
        emit(e_i(6'h05, 5'd5, 5'd0, 16'hFFFD));     // 258 back to 250
        emit(e_to(5'd6));                           // 25C
        emit_halt();                                // 260
        run(5, 1'b0);
        chk("R5 taken bne skips next", tx_log[0], 32'd0);
        chk("R5 untaken bne falls through", tx_log[1], 32'd7);
        chk("R6 jal link value", tx_log[2], 32'h220);
        chk("R6 jr target", tx_log[3], 32'h23C);
        chk("R5 backward bne loop", tx_log[4], 32'd6);
        chk("R6 no extra words sent", tx_cnt, 32'd5);

        // host input
        clear_prog();
        emit(e_from(5'd5));
        emit(e_from(5'd6));
        emit(e_r(6'h00, 5'd5, 5'd6, 5'd7, 6'h21));
        emit(e_to(5'd7));
        emit(e_to(5'd5));
        emit_halt();
        run(2, 1'b0);
        chk("R8 host words summed", tx_log[0], 32'h3333_3333);
        chk("R8 first host word", tx_log[1], 32'h1111_1111);
        chk("R7 send count", tx_cnt, 32'd2);

        // illegal word
        clear_prog();
        emit(e_i(6'h09, 5'd0, 5'd1, 16'd3));
        emit(e_to(5'd1));
        emit(32'hFC00_0000);
        emit(e_to(5'd1));
        emit_halt();
        run(1, 1'b0);
        chk("R9 err raised", {31'd0, err}, 32'd1);
        chk("R9 fetch frozen", imem_addr, 32'h208);
        chk("R9 nothing sent after fault", tx_cnt, 32'd1);
        repeat (5) @(negedge clk);
        #2;
        chk("R9 err still set", {31'd0, err}, 32'd1);
        chk("R9 store strobe quiet", {31'd0, dmem_we}, 32'd0);

        // random arithmetic programs
        for (int r = 0; r < 4; r++) begin
            int sel;
            logic [4:0] d, s, t;
            logic [15:0] im;
            clear_prog();
            for (int k = 0; k < 8; k++) mdl[k] = 32'd0;
            for (int i = 0; i < 24; i++) begin
                sel = int'($urandom % 3);
                d   = 5'(1 + ($urandom % 7));
                s   = 5'($urandom % 8);
                t   = 5'($urandom % 8);
                im  = 16'($urandom);
                if (sel == 0) begin
                    emit(e_r(6'h00, s, t, d, 6'h21));
                    mdl[d] = mdl[s] + mdl[t];
                end else if (sel == 1) begin
                    emit(e_i(6'h09, s, d, im));
                    mdl[d] = mdl[s] + sx(im);
                end else begin
                    emit(e_r(6'h1C, s, t, d, 6'h02));
                    mdl[d] = mdl[s] * mdl[t];
                end
            end
            for (int k = 1; k < 8; k++) emit(e_to(5'(k)));
            emit_halt();
            run(7, 1'b1);
            for (int k = 1; k < 8; k++)
                chk($sformatf("R2 random r%0d", k), tx_log[k-1], mdl[k]);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule